// File: doc/BRIEF.md
# SPI Slave Register Port

A serial slave that lets an external SPI master read and write a file of 64 byte-wide registers. The serial pins are sampled by a faster system clock: SCLK, chip select and the data input each pass through a two-flop synchronizer, and the SCLK edges are found in the system clock domain. Each SCLK level must therefore last at least four system clock cycles. The port runs in SPI mode 3: SCLK idles high, the slave samples data on the rising edge and changes its output on the falling edge. Data moves most significant bit first.

A transaction starts when chip select falls. The master then sends one command byte: bit 7 is the direction (1 = read), bit 6 is the burst flag and bits 5:0 are the register address. One or more data bytes follow. If the burst flag is set, the register pointer steps by one after each data byte. If it is clear, only the addressed register is accessed.

Bit 6 of register 0x31 selects the wiring. When it is 0 the port is 4-wire and read data comes out on `sdo`. When it is 1 the port is 3-wire and read data is driven back on a shared line through `sdio_out`, gated by `sdio_oe`.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0x00, and `sdo`, `sdio_out` and `sdio_oe` are low.
- R2: Input bits are taken on SCLK rising edges. Read data is shifted out MSB first and changes after falling edges, so the first bit of each read byte is valid before that byte's first rising edge.
- R3: In the command byte, bit 7 = 1 means read, bit 6 is the burst flag and bits 5:0 are the start address.
- R4: With the burst flag clear, only the addressed register is accessed. Further write bytes in the same transaction are discarded, and further read bytes return the same register again.
- R5: With the burst flag set, the pointer advances by one after every data byte and wraps from 63 to 0.
- R6: A written byte commits on the eighth rising SCLK edge of its data byte. If chip select is released before that edge is seen, or in the same synchronized cycle as that edge, the partial byte is discarded.
- R7: If bit 6 of register 0x31 is 0, read data appears on `sdo` and `sdio_oe` stays low. If it is 1, read data appears on `sdio_out` with `sdio_oe` high, and `sdo` stays low.
- R8: `sdio_oe` is low during the command byte, during write data and after chip select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| csn | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in (the shared line's value in 3-wire mode) |
| sdo | output | 1 | Serial data out in 4-wire mode |
| sdio_out | output | 1 | Value driven onto the shared line in 3-wire mode |
| sdio_oe | output | 1 | Drive enable for the shared line |

## Verification
Two events can land in the same system cycle: the release of chip select and the eighth rising SCLK edge of a write byte. Both inputs go through synchronizers of equal depth. The bench raises both pins at the same instant, so the two events are seen together. It judges the result by reading the register back and expecting the old contents. A control case releases chip select only after that edge and must see the new value, and a five-bit partial byte must also leave the register unchanged.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW       = 6,
  parameter int SYNC     = 2,
  parameter int FMT_ADDR = 49,
  parameter int MODE_BIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csn,
  input  logic sdi,
  output logic sdo,
  output logic sdio_out,
  output logic sdio_oe
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] FMT_IDX = AW'(FMT_ADDR);

  logic [SYNC:0]   sclk_q;
  logic [SYNC-1:0] csn_q, sdi_q;
  logic [7:0]      mem [DEPTH];
  logic            in_data, rw, mb, done, out_q, drv_q;
  logic [2:0]      cnt;
  logic [6:0]      sh;
  logic [AW-1:0]   ptr;
  logic [7:0]      tx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '1;
      csn_q  <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], sclk};
      csn_q  <= {csn_q[SYNC-2:0], csn};
      sdi_q  <= {sdi_q[SYNC-2:0], sdi};
    end

  wire       cs_act    = ~csn_q[SYNC-1];
  wire       sdi_s     = sdi_q[SYNC-1];
  wire       rise      = cs_act & sclk_q[SYNC-1] & ~sclk_q[SYNC];
  wire       fall      = cs_act & ~sclk_q[SYNC-1] & sclk_q[SYNC];
  wire       last      = rise & (cnt == 3'd7);
  wire [7:0] rx_byte   = {sh, sdi_s};
  wire       three_wire = mem[FMT_IDX][MODE_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_data <= 1'b0; rw <= 1'b0; mb <= 1'b0; done <= 1'b0;
      cnt <= '0; sh <= '0; ptr <= '0; tx <= '0;
      out_q <= 1'b0; drv_q <= 1'b0;
    end else if (!cs_act) begin
      in_data <= 1'b0; done <= 1'b0; cnt <= '0;
      out_q <= 1'b0; drv_q <= 1'b0;
    end else begin
      if (rise) begin
        sh  <= rx_byte[6:0];
        cnt <= cnt + 3'd1;
        if (last) begin
          if (!in_data) begin
            in_data <= 1'b1;
            rw      <= rx_byte[7];
            mb      <= rx_byte[6];
            ptr     <= rx_byte[AW-1:0];
            tx      <= mem[rx_byte[AW-1:0]];
          end else if (mb) begin
            ptr <= ptr + 1'b1;
            tx  <= mem[ptr + 1'b1];
          end else begin
            done <= 1'b1;
          end
        end
      end
      if (fall && in_data && rw) begin
        out_q <= tx[~cnt];
        drv_q <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cs_act && last && in_data && !rw && !done) begin
      mem[ptr] <= rx_byte;
    end

  assign sdo      = drv_q & ~three_wire & out_q;
  assign sdio_out = drv_q & three_wire & out_q;
  assign sdio_oe  = drv_q & three_wire;
endmodule

module spi_regport_chk #(parameter int AW = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_act,
  input logic          in_data,
  input logic          rw,
  input logic          mb,
  input logic          last,
  input logic [2:0]    cnt,
  input logic [AW-1:0] ptr,
  input logic          sdo,
  input logic          sdio_oe
);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!sdio_oe && !sdo));
  p_cmd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !in_data) |-> !sdio_oe);
  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !rw) |-> (!sdio_oe && !sdo));
  p_bump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && last && in_data && mb) |=> ptr == AW'($past(ptr) + 1'b1));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !mb) |=> ptr == $past(ptr));
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> cnt == 3'd0);
  p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> (in_data && rw));
endmodule

bind spi_regport spi_regport_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .in_data(in_data), .rw(rw),
  .mb(mb), .last(last), .cnt(cnt), .ptr(ptr), .sdo(sdo), .sdio_oe(sdio_oe)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, csn = 1'b1, sdi = 1'b0;
  logic sdo, sdio_out, sdio_oe;
  int checks = 0, fails = 0;
  logic tw = 1'b0;
  logic oe_any;

  always #4 clk = ~clk;

  spi_regport uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
                   .sdo(sdo), .sdio_out(sdio_out), .sdio_oe(sdio_oe));

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] mo, output logic [7:0] mi, input int nbits = 8);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = mo[7-i];
      wait_clk(8);
      mi[7-i] = tw ? sdio_out : sdo;
      oe_any  = oe_any | sdio_oe;
      if (sdio_oe) sdi = sdio_out;
      sclk = 1'b1;
      wait_clk(8);
    end
  endtask

  task automatic cs_lo();
    csn = 1'b0; oe_any = 1'b0; wait_clk(8);
  endtask

  task automatic cs_hi();
    csn = 1'b1; wait_clk(8);
  endtask

  task automatic wr1(input int a, input logic [7:0] d);
    logic [7:0] r;
    cs_lo(); xbyte({2'b00, 6'(a)}, r); xbyte(d, r); cs_hi();
  endtask

  task automatic rd1(input int a, output logic [7:0] d, output logic oe_cmd, output logic oe_dat);
    logic [7:0] r;
    cs_lo(); xbyte({2'b10, 6'(a)}, r); oe_cmd = oe_any; oe_any = 1'b0;
    xbyte(8'h00, d); oe_dat = oe_any; cs_hi();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, r;
    logic oc, od;
    wait_clk(3);
    chk("R1 sdo", sdo, 0);
    chk("R1 sdio_oe", sdio_oe, 0);
    chk("R1 sdio_out", sdio_out, 0);
    rst_n = 1'b1;
    wait_clk(4);

    rd1(0, d, oc, od);  chk("R1 reg0 after reset", d, 0);
    rd1(63, d, oc, od); chk("R1 reg63 after reset", d, 0);
    rd1(49, d, oc, od); chk("R1 reg49 after reset", d, 0);

    for (int a = 0; a < 64; a++) if (a != 49) wr1(a, pat(a));
    for (int a = 0; a < 64; a++) if (a != 49) begin
      rd1(a, d, oc, od);
      chk("R3 R2 single read", d, pat(a));
      chk("R7 4-wire oe low", od, 0);
    end

    cs_lo(); xbyte(8'h7E, r);
    for (int k = 0; k < 4; k++) xbyte(8'hC0 + 8'(k), r);
    cs_hi();
    rd1(62, d, oc, od); chk("R5 burst write 62", d, 8'hC0);
    rd1(63, d, oc, od); chk("R5 burst write 63", d, 8'hC1);
    rd1(0, d, oc, od);  chk("R5 wrap write 0", d, 8'hC2);
    rd1(1, d, oc, od);  chk("R5 wrap write 1", d, 8'hC3);
    cs_lo(); xbyte(8'hFE, r);
    for (int k = 0; k < 4; k++) begin
      xbyte(8'h00, d); chk("R5 burst read wrap", d, 8'hC0 + 8'(k));
    end
    cs_hi();

    cs_lo(); xbyte(8'h0A, r); xbyte(8'h11, r); xbyte(8'h22, r); xbyte(8'h33, r); cs_hi();
    rd1(10, d, oc, od); chk("R4 single write first byte", d, 8'h11);
    rd1(11, d, oc, od); chk("R4 neighbour untouched", d, pat(11));
    cs_lo(); xbyte(8'h8A, r); xbyte(8'h00, d); chk("R4 read first", d, 8'h11);
    xbyte(8'h00, d); chk("R4 read repeats", d, 8'h11); cs_hi();

    cs_lo(); xbyte(8'h14, r); xbyte(8'hFF, r, 5); cs_hi();
    rd1(20, d, oc, od); chk("R6 partial byte discarded", d, pat(20));

    cs_lo(); xbyte(8'h15, r); xbyte(8'hA5, r, 7);
    sclk = 1'b0; sdi = 1'b1; wait_clk(8);
    sclk = 1'b1; csn = 1'b1; wait_clk(8);
    rd1(21, d, oc, od); chk("R6 release with eighth edge discards", d, pat(21));

    cs_lo(); xbyte(8'h15, r); xbyte(8'hA5, r, 7);
    sclk = 1'b0; sdi = 1'b1; wait_clk(8);
    sclk = 1'b1; wait_clk(8); cs_hi();
    rd1(21, d, oc, od); chk("R6 eighth edge commits", d, 8'hA5);

    wr1(49, 8'h40);
    tw = 1'b1;
    rd1(49, d, oc, od);
    chk("R7 3-wire read mode reg", d, 8'h40);
    chk("R8 oe low in command", oc, 0);
    chk("R7 oe high in read data", od, 1);
    chk("R8 oe low after release", sdio_oe, 0);
    rd1(5, d, oc, od); chk("R7 3-wire read", d, pat(5));
    cs_lo(); xbyte(8'h0C, r); oe_any = 1'b0; xbyte(8'h5C, r);
    chk("R8 oe low in write", oe_any, 0); cs_hi();
    rd1(12, d, oc, od); chk("R7 3-wire write", d, 8'h5C);
    cs_lo(); xbyte(8'hC5, r); tw = 1'b0; xbyte(8'h00, d); tw = 1'b1;
    chk("R7 sdo low in 3-wire", d, 0); cs_hi();

    wr1(49, 8'h00);
    tw = 1'b0;
    rd1(12, d, oc, od);
    chk("R7 back to 4-wire", d, 8'h5C);
    chk("R7 4-wire oe low", od, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule